// File: doc/BRIEF.md
# Segment Address Translator

This block maps a narrow virtual address onto a physical address through a small table of segment descriptors. The high bits of each virtual address pick one descriptor, and the low bits are an offset into that segment. The offset is checked against the descriptor's limit and its enable flag. If both checks pass, the offset is added to the descriptor's base.

Descriptors are loaded through a plain write port: a segment number together with its base, limit and enable flag. Translation requests enter on a valid/ready stream. Each result leaves on a second valid/ready stream one cycle after the request is accepted, and it carries either the physical address or a fault flag. The result stage holds a single entry. While an unaccepted result sits in that stage, the request side deasserts ready. Once the result is accepted or the stage is empty, a new request is taken every cycle.

Top module: `seg_xlate`

## Requirements
- R1: The top SEG_W bits of `req_vaddr` (bits 7:6 by default) select the descriptor. The remaining OFF_W bits (5:0) are the offset.
- R2: For an enabled segment with offset < limit, `rsp_paddr` equals base + offset modulo 2^PA_W, and `rsp_fault` is 0.
- R3: An access to a segment whose enable flag is 0 returns `rsp_fault` = 1.
- R4: An offset greater than or equal to the segment's limit returns `rsp_fault` = 1. An offset of limit-1 is still translated.
- R5: Whenever `rsp_fault` is 1, `rsp_paddr` is 0.
- R6: Reset clears every enable flag, so every access after reset faults until a descriptor is written.
- R7: A descriptor write is used by requests accepted after that write's clock edge. A request accepted in the same cycle as a write sees the old descriptor.
- R8: A request accepted at a clock edge produces `rsp_valid` = 1 after that edge. No response appears without an accepted request.
- R9: While `rsp_valid` = 1 and `rsp_ready` = 0, the response holds stable and `req_ready` = 0. Otherwise `req_ready` = 1.
- R10: A limit of 0 makes every offset in that segment fault.
- R11: A limit of 2^OFF_W (64, the widest the limit field holds) allows every offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Descriptor write strobe |
| wr_seg | input | SEG_W | Descriptor index to write |
| wr_base | input | PA_W | Base address to store |
| wr_limit | input | OFF_W+1 | Segment length in bytes |
| wr_valid | input | 1 | Enable flag to store |
| req_valid | input | 1 | Translate request present |
| req_ready | output | 1 | Request accepted this cycle when high with req_valid |
| req_vaddr | input | VA_W | Virtual address to translate |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_paddr | output | PA_W | Translated address, 0 on fault |
| rsp_fault | output | 1 | Access refused |

## Verification
The bench goes after the edges of each segment: offset limit-1 against offset limit, limit 0, and the full limit of 64. A design that used `>` in place of `>=` would translate the first byte past the segment. A design with the limit field one bit too narrow would fault everywhere in a full-size segment. The bench also issues a write and a request in the same cycle, then repeats the request. A design that forwarded the write would return the new base one request too early. A base near the top of the space checks that the sum wraps rather than saturating. Holding `rsp_ready` low checks that a stalled response neither changes nor gets overwritten by a new request.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;
  // Outcome of one translation attempt
  typedef enum logic [1:0] {
    XL_OK     = 2'd0,
    XL_NOSEG  = 2'd1,
    XL_BOUNDS = 2'd2
  } xl_cause_e;
endpackage

// File: rtl/seg_desc_table.sv
module seg_desc_table #(
  parameter int unsigned SEG_W = 2,
  parameter int unsigned OFF_W = 6,
  parameter int unsigned PA_W  = 8,
  localparam int unsigned NSEG  = 1 << SEG_W,
  localparam int unsigned LIM_W = OFF_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [SEG_W-1:0] wr_seg,
  input  logic [PA_W-1:0]  wr_base,
  input  logic [LIM_W-1:0] wr_limit,
  input  logic             wr_valid,
  input  logic [SEG_W-1:0] rd_seg,
  output logic [PA_W-1:0]  rd_base,
  output logic [LIM_W-1:0] rd_limit,
  output logic             rd_valid
);
  logic [PA_W-1:0]  base_q [NSEG];
  logic [LIM_W-1:0] lim_q  [NSEG];
  logic [NSEG-1:0]  vld_q;

  for (genvar g = 0; g < NSEG; g++) begin : g_entry
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        base_q[g] <= '0;
        lim_q[g]  <= '0;
        vld_q[g]  <= 1'b0;
      end else if (wr_en && (wr_seg == SEG_W'(g))) begin
        base_q[g] <= wr_base;
        lim_q[g]  <= wr_limit;
        vld_q[g]  <= wr_valid;
      end
    end
  end

  // Registered storage read combinationally: a same-cycle write is not seen
  assign rd_base  = base_q[rd_seg];
  assign rd_limit = lim_q[rd_seg];
  assign rd_valid = vld_q[rd_seg];
endmodule

// File: rtl/seg_bounds_add.sv
module seg_bounds_add
  import seg_xlate_pkg::*;
#(
  parameter int unsigned OFF_W = 6,
  parameter int unsigned PA_W  = 8,
  localparam int unsigned LIM_W = OFF_W + 1
) (
  input  logic [OFF_W-1:0] offset,
  input  logic [PA_W-1:0]  base,
  input  logic [LIM_W-1:0] limit,
  input  logic             seg_on,
  output xl_cause_e        cause,
  output logic [PA_W-1:0]  paddr
);
  logic             out_of_range;
  logic [PA_W-1:0]  sum;

  assign out_of_range = ({1'b0, offset} >= limit);
  assign sum          = base + PA_W'(offset);

  always_comb begin
    if (!seg_on)           cause = XL_NOSEG;
    else if (out_of_range) cause = XL_BOUNDS;
    else                   cause = XL_OK;
    paddr = (cause == XL_OK) ? sum : '0;
  end
endmodule

// File: rtl/seg_rsp_stage.sv
module seg_rsp_stage #(
  parameter int unsigned PA_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [PA_W-1:0] in_paddr,
  input  logic            in_fault,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [PA_W-1:0] out_paddr,
  output logic            out_fault
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_paddr <= '0;
      out_fault <= 1'b0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_paddr <= in_paddr;
        out_fault <= in_fault;
      end
    end
  end
endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
  import seg_xlate_pkg::*;
#(
  parameter int unsigned SEG_W = 2,
  parameter int unsigned OFF_W = 6,
  parameter int unsigned PA_W  = 8,
  localparam int unsigned VA_W  = SEG_W + OFF_W,
  localparam int unsigned LIM_W = OFF_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [SEG_W-1:0] wr_seg,
  input  logic [PA_W-1:0]  wr_base,
  input  logic [LIM_W-1:0] wr_limit,
  input  logic             wr_valid,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [VA_W-1:0]  req_vaddr,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic [PA_W-1:0]  rsp_paddr,
  output logic             rsp_fault
);
  logic [SEG_W-1:0] seg;
  logic [OFF_W-1:0] off;
  logic [PA_W-1:0]  d_base;
  logic [LIM_W-1:0] d_limit;
  logic             d_valid;
  xl_cause_e        cause;
  logic [PA_W-1:0]  paddr;

  assign seg = req_vaddr[VA_W-1:OFF_W];
  assign off = req_vaddr[OFF_W-1:0];

  seg_desc_table #(.SEG_W(SEG_W), .OFF_W(OFF_W), .PA_W(PA_W)) u_table (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_seg(wr_seg), .wr_base(wr_base),
    .wr_limit(wr_limit), .wr_valid(wr_valid),
    .rd_seg(seg), .rd_base(d_base), .rd_limit(d_limit), .rd_valid(d_valid)
  );

  seg_bounds_add #(.OFF_W(OFF_W), .PA_W(PA_W)) u_check (
    .offset(off), .base(d_base), .limit(d_limit), .seg_on(d_valid),
    .cause(cause), .paddr(paddr)
  );

  seg_rsp_stage #(.PA_W(PA_W)) u_rsp (
    .clk(clk), .rst_n(rst_n),
    .in_valid(req_valid), .in_ready(req_ready),
    .in_paddr(paddr), .in_fault(cause != XL_OK),
    .out_valid(rsp_valid), .out_ready(rsp_ready),
    .out_paddr(rsp_paddr), .out_fault(rsp_fault)
  );
endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk #(
  parameter int unsigned SEG_W = 2,
  parameter int unsigned OFF_W = 6,
  parameter int unsigned PA_W  = 8,
  localparam int unsigned NSEG  = 1 << SEG_W,
  localparam int unsigned VA_W  = SEG_W + OFF_W,
  localparam int unsigned LIM_W = OFF_W + 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [SEG_W-1:0] wr_seg,
  input logic [LIM_W-1:0] wr_limit,
  input logic             wr_valid,
  input logic             req_valid,
  input logic             req_ready,
  input logic [VA_W-1:0]  req_vaddr,
  input logic             rsp_valid,
  input logic             rsp_ready,
  input logic [PA_W-1:0]  rsp_paddr,
  input logic             rsp_fault
);
  // Shadow of enable flags and limits, rebuilt from the write port
  logic [NSEG-1:0]  sh_vld;
  logic [LIM_W-1:0] sh_lim [NSEG];
  logic             acc;
  logic [SEG_W-1:0] a_seg;
  logic [OFF_W-1:0] a_off;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_vld <= '0;
      for (int i = 0; i < NSEG; i++) sh_lim[i] <= '0;
    end else if (wr_en) begin
      sh_vld[wr_seg] <= wr_valid;
      sh_lim[wr_seg] <= wr_limit;
    end
  end

  assign acc   = req_valid && req_ready;
  assign a_seg = req_vaddr[VA_W-1:OFF_W];
  assign a_off = req_vaddr[OFF_W-1:0];

  AST_DISABLED_FAULTS: assert property (@(posedge clk) disable iff (!rst_n)
    acc && !sh_vld[a_seg] |=> rsp_valid && rsp_fault); // R3
  AST_BOUNDS_FAULTS: assert property (@(posedge clk) disable iff (!rst_n)
    acc && ({1'b0, a_off} >= sh_lim[a_seg]) |=> rsp_valid && rsp_fault); // R4
  AST_FAULT_ZERO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_fault |-> rsp_paddr == '0); // R5
  AST_RESP_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> rsp_valid); // R8
  AST_NO_SPURIOUS_RESP: assert property (@(posedge clk) disable iff (!rst_n)
    !acc && !(rsp_valid && !rsp_ready) |=> !rsp_valid); // R8
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_paddr) && $stable(rsp_fault)); // R9
  AST_STALL_BLOCKS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |-> !req_ready); // R9
endmodule

bind seg_xlate seg_xlate_chk #(.SEG_W(SEG_W), .OFF_W(OFF_W), .PA_W(PA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_seg(wr_seg),
  .wr_limit(wr_limit), .wr_valid(wr_valid),
  .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
  .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault)
);

// File: tb/seg_xlate_tb.sv
`timescale 1ns/1ps
module seg_xlate_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_seg = '0;
  logic [7:0] wr_base = '0;
  logic [6:0] wr_limit = '0;
  logic       wr_valid = 1'b0;
  logic       req_valid = 1'b0;
  logic       req_ready;
  logic [7:0] req_vaddr = '0;
  logic       rsp_valid;
  logic       rsp_ready = 1'b1;
  logic [7:0] rsp_paddr;
  logic       rsp_fault;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  // Bench model of the descriptor table
  logic [7:0] m_base [4];
  logic [6:0] m_lim  [4];
  logic       m_vld  [4];

  // Scoreboard
  logic [7:0] q_addr [$];
  logic       q_flt  [$];
  string      q_tag  [$];

  always #2 clk = ~clk;

  seg_xlate u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_seg(wr_seg),
    .wr_base(wr_base), .wr_limit(wr_limit), .wr_valid(wr_valid),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault)
  );

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic void expect_xl(input logic [7:0] va, input string tag);
    logic [1:0] s;
    logic [5:0] o;
    s = va[7:6];
    o = va[5:0];
    if (!m_vld[s] || ({1'b0, o} >= m_lim[s])) begin
      q_addr.push_back(8'h00);
      q_flt.push_back(1'b1);
    end else begin
      q_addr.push_back(m_base[s] + {2'b00, o});
      q_flt.push_back(1'b0);
    end
    q_tag.push_back(tag);
  endfunction

  // Driver: optional descriptor write and optional request in one cycle
  task automatic issue(input bit dw, input logic [1:0] ws, input logic [7:0] wb,
                       input logic [6:0] wl, input logic wv,
                       input bit dr, input logic [7:0] va, input string tag);
    @(posedge clk); #1;
    if (dr) expect_xl(va, tag);   // expected value uses the old descriptor
    wr_en = dw; wr_seg = ws; wr_base = wb; wr_limit = wl; wr_valid = wv;
    req_valid = dr; req_vaddr = va;
    if (dw) begin m_base[ws] = wb; m_lim[ws] = wl; m_vld[ws] = wv; end
    @(negedge clk);
    while (dr && !req_ready) @(negedge clk);
    @(posedge clk); #1;
    wr_en = 1'b0; req_valid = 1'b0;
  endtask

  task automatic wr(input logic [1:0] s, input logic [7:0] b, input logic [6:0] l, input logic v);
    issue(1'b1, s, b, l, v, 1'b0, 8'h00, "");
  endtask

  task automatic xl(input logic [7:0] va, input string tag);
    issue(1'b0, 2'd0, 8'h00, 7'd0, 1'b0, 1'b1, va, tag);
  endtask

  // Monitor: compare each delivered response against the queue
  always @(negedge clk) begin
    if (rst_n && rsp_valid && rsp_ready) begin
      if (q_addr.size() == 0) begin
        check(1, 0, "R8 unexpected response");
      end else begin
        logic [7:0] ea;
        logic       ef;
        string      et;
        ea = q_addr.pop_front();
        ef = q_flt.pop_front();
        et = q_tag.pop_front();
        check({31'd0, rsp_fault}, {31'd0, ef}, {et, " fault"});
        check({24'd0, rsp_paddr}, {24'd0, ea}, {et, " paddr"});
      end
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) begin m_base[i] = '0; m_lim[i] = '0; m_vld[i] = 1'b0; end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check({31'd0, rsp_valid}, 32'd0, "R8 reset rsp_valid");
    check({31'd0, req_ready}, 32'd1, "R9 reset req_ready");

    // R6: nothing enabled after reset
    for (int s = 0; s < 4; s++) xl({s[1:0], 6'd0}, "R6 post-reset fault");

    // Load example segments
    wr(2'd0, 8'h10, 7'd32, 1'b1);
    wr(2'd1, 8'h50, 7'd32, 1'b1);
    wr(2'd2, 8'h70, 7'd24, 1'b1);
    wr(2'd3, 8'hB0, 7'd16, 1'b1);

    xl(8'b00_000101, "R1 R2 seg0 off5");
    xl(8'b00_011111, "R4 seg0 last byte");
    xl(8'b01_000000, "R1 R2 seg1 off0");
    xl(8'b10_010111, "R4 seg2 last byte");
    xl(8'b10_011000, "R4 seg2 at limit");
    xl(8'b11_000000, "R2 seg3 off0");
    xl(8'b11_001111, "R4 seg3 last byte");
    xl(8'b11_110000, "R4 stack past limit");

    // R3: disable a segment
    wr(2'd1, 8'h50, 7'd32, 1'b0);
    xl(8'b01_000001, "R3 disabled segment");

    // R7: same-cycle write returns old, next request sees new
    issue(1'b1, 2'd2, 8'hF0, 7'd40, 1'b1, 1'b1, 8'b10_000001, "R7 same-cycle old");
    xl(8'b10_000001, "R7 next request new");
    xl(8'b10_010100, "R2 wrap of sum");

    // R10: zero-length segment
    wr(2'd0, 8'h20, 7'd0, 1'b1);
    xl(8'b00_000000, "R10 limit zero");

    // R11: full-length segment
    wr(2'd0, 8'h00, 7'd64, 1'b1);
    xl(8'b00_111111, "R11 full limit top offset");

    // R9: back-pressure
    @(posedge clk); #1 rsp_ready = 1'b0;
    xl(8'b11_000011, "R9 stalled response");
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check({31'd0, rsp_valid}, 32'd1, "R9 held valid");
      check({31'd0, req_ready}, 32'd0, "R9 req blocked");
      check({24'd0, rsp_paddr}, 32'hB3, "R9 held paddr");
    end
    @(posedge clk); #1 rsp_ready = 1'b1;

    repeat (4) @(posedge clk);
    check(q_addr.size(), 0, "R8 all responses delivered");
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule